// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

This block holds a bank of 32-bit mailboxes that processor cores use to signal one another. Each core owns four mailboxes, so four cores give sixteen. A sender writes a bit pattern into a mailbox through the set window. The written ones are ORed into the mailbox. The receiving core reads the mailbox through the clear window, picks the lowest set bit, and writes that bit back to the clear window to acknowledge it.

Every mailbox drives its own level interrupt request. The request stays high while any bit of the mailbox is one, so a per-core interrupt router can take it directly. The bank has two independent write ports and one read port, so a set and a clear can reach the same mailbox in one cycle. Bus protocol wrapping and interrupt enable masking belong to other blocks.

Top module: `mbox_bank`

## Requirements
- R1: After reset every mailbox reads zero and every bit of `mbox_irq` is low.
- R2: A write to byte address 0x080 + 16*core + 4*box ORs the write data into that mailbox. Core and box each run from 0 to 3. Bits already set stay set.
- R3: A write to byte address 0x0C0 + 16*core + 4*box clears exactly those mailbox bits where the write data is one.
- R4: A read of a clear-window address returns that mailbox's value on `rd_data` one cycle after `rd_en` is sampled. A read of any other address returns zero.
- R5: `mbox_irq[4*core+box]` is high exactly when that mailbox is nonzero. It changes in the same cycle as the mailbox value, which is one cycle after the write is sampled.
- R6: When a set and a clear reach the same mailbox in one cycle, bits named by both end up set. Bits named only by the clear end up cleared.
- R7: A write whose address lies outside both windows, or whose two low address bits are not zero, changes no mailbox.
- R8: When both write ports set the same mailbox in one cycle, the mailbox receives the OR of both data words.
- R9: A read sampled in the same cycle as a write to the same mailbox returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | 8 | Write port A byte address |
| wa_data | input | 32 | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | 8 | Write port B byte address |
| wb_data | input | 32 | Write port B data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Registered read data |
| mbox_irq | output | 16 | Per-mailbox level interrupt, index 4*core+box |

## Verification
Writes are sampled on a rising edge. The mailbox values and their interrupt lines change right after that same edge. Read data is registered and appears right after the edge that samples `rd_en`, and it holds the value from before any write sampled on that edge. The driver applies stimulus on falling edges and records the expected read data at the moment it drives the read. The monitor captures `rd_en` at the next rising edge and compares `rd_data` on the falling edge that follows. Interrupt checks are taken on the falling edge after the write's rising edge, against a model updated at drive time.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DEF_CORES     = 4;
  localparam int unsigned DEF_PER_CORE  = 4;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_ADDR_W    = 8;
  localparam int unsigned DEF_SET_BASE  = 'h80;
  localparam int unsigned DEF_CLR_BASE  = 'hC0;
  localparam int unsigned WORD_BYTES    = 4;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BOXES = 16,
  parameter int unsigned SET_BASE  = 'h80,
  parameter int unsigned CLR_BASE  = 'hC0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BOXES-1:0] set_sel,
  output logic [NUM_BOXES-1:0] clr_sel
);
  import mbox_pkg::*;
  localparam int unsigned IDX_W = (NUM_BOXES > 1) ? $clog2(NUM_BOXES) : 1;
  localparam int unsigned SPAN  = NUM_BOXES * WORD_BYTES;
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] a_ext;
  logic [EXT_W-1:0] set_off, clr_off;
  logic             aligned, in_set, in_clr;
  logic [IDX_W-1:0] set_idx, clr_idx;
  win_e             win;

  always_comb begin
    a_ext   = {1'b0, addr};
    aligned = (addr[1:0] == 2'b00);
    set_off = a_ext - EXT_W'(SET_BASE);
    clr_off = a_ext - EXT_W'(CLR_BASE);
    in_set  = (a_ext >= EXT_W'(SET_BASE)) && (a_ext < EXT_W'(SET_BASE + SPAN));
    in_clr  = (a_ext >= EXT_W'(CLR_BASE)) && (a_ext < EXT_W'(CLR_BASE + SPAN));
    set_idx = IDX_W'(set_off >> 2);
    clr_idx = IDX_W'(clr_off >> 2);
    if (!en || !aligned) win = WIN_NONE;
    else if (in_set)     win = WIN_SET;
    else if (in_clr)     win = WIN_CLR;
    else                 win = WIN_NONE;
  end

  generate
    for (genvar i = 0; i < NUM_BOXES; i++) begin : g_sel
      assign set_sel[i] = (win == WIN_SET) && (set_idx == IDX_W'(i));
      assign clr_sel[i] = (win == WIN_CLR) && (clr_idx == IDX_W'(i));
    end
  endgenerate

  // R7: at most one mailbox selected per port, never both windows at once
  a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_sel, clr_sel}));
  // R7: an unaligned address selects nothing
  a_r7_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |-> ((set_sel == '0) && (clr_sel == '0)));
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] value,
  output logic              irq
);
  logic [DATA_W-1:0] val_q, val_d;
  logic              irq_q, irq_d;
  logic              upd_en;

  always_comb begin
    upd_en = (|set_mask) || (|clr_mask);
    val_d  = (val_q & ~clr_mask) | set_mask;
    irq_d  = (val_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      irq_q <= 1'b0;
    end else if (upd_en) begin
      val_q <= val_d;
      irq_q <= irq_d;
    end
  end

  assign value = val_q;
  assign irq   = irq_q;

  // R5: interrupt level matches a nonzero mailbox
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (val_q != '0));
  // R2: set bits are present after the edge
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((val_q & $past(set_mask)) == $past(set_mask)));
  // R3: cleared bits not also set are gone after the edge
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_mask)) |=> ((val_q & $past(clr_mask & ~set_mask)) == '0));
  // R6: untouched bits keep their value
  a_r6_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((val_q & ~$past(set_mask | clr_mask)) == ($past(val_q) & ~$past(set_mask | clr_mask))));
endmodule

// File: rtl/mbox_read_port.sv
module mbox_read_port #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_BOXES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [NUM_BOXES-1:0]        hit,
  input  logic [NUM_BOXES*DATA_W-1:0] values,
  output logic [DATA_W-1:0]           rd_data
);
  logic [DATA_W-1:0] rd_q, rd_d;

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_BOXES; i++) begin
      if (hit[i]) rd_d = rd_d | values[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // R4: a read that hits no clear-window mailbox returns zero
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (hit == '0)) |=> (rd_data == '0));
  // R4: read data holds while no read is issued
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int unsigned CORES    = mbox_pkg::DEF_CORES,
  parameter int unsigned PER_CORE = mbox_pkg::DEF_PER_CORE,
  parameter int unsigned DATA_W   = mbox_pkg::DEF_DATA_W,
  parameter int unsigned ADDR_W   = mbox_pkg::DEF_ADDR_W,
  parameter int unsigned SET_BASE = mbox_pkg::DEF_SET_BASE,
  parameter int unsigned CLR_BASE = mbox_pkg::DEF_CLR_BASE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wa_en,
  input  logic [ADDR_W-1:0]         wa_addr,
  input  logic [DATA_W-1:0]         wa_data,
  input  logic                      wb_en,
  input  logic [ADDR_W-1:0]         wb_addr,
  input  logic [DATA_W-1:0]         wb_data,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [CORES*PER_CORE-1:0] mbox_irq
);
  localparam int unsigned NUM_BOXES = CORES * PER_CORE;

  logic                        rst_sync_n;
  logic [NUM_BOXES-1:0]        a_set, a_clr, b_set, b_clr, r_set, r_clr;
  logic [NUM_BOXES*DATA_W-1:0] values;

  mbox_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mbox_addr_dec #(.ADDR_W(ADDR_W), .NUM_BOXES(NUM_BOXES),
                  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)) u_dec_a (
    .clk(clk), .rst_n(rst_sync_n), .en(wa_en), .addr(wa_addr),
    .set_sel(a_set), .clr_sel(a_clr)
  );

  mbox_addr_dec #(.ADDR_W(ADDR_W), .NUM_BOXES(NUM_BOXES),
                  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)) u_dec_b (
    .clk(clk), .rst_n(rst_sync_n), .en(wb_en), .addr(wb_addr),
    .set_sel(b_set), .clr_sel(b_clr)
  );

  mbox_addr_dec #(.ADDR_W(ADDR_W), .NUM_BOXES(NUM_BOXES),
                  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)) u_dec_r (
    .clk(clk), .rst_n(rst_sync_n), .en(rd_en), .addr(rd_addr),
    .set_sel(r_set), .clr_sel(r_clr)
  );

  generate
    for (genvar i = 0; i < NUM_BOXES; i++) begin : g_box
      logic [DATA_W-1:0] set_m, clr_m;
      always_comb begin
        set_m = ({DATA_W{a_set[i]}} & wa_data) | ({DATA_W{b_set[i]}} & wb_data);
        clr_m = ({DATA_W{a_clr[i]}} & wa_data) | ({DATA_W{b_clr[i]}} & wb_data);
      end
      mbox_cell #(.DATA_W(DATA_W)) u_cell (
        .clk(clk), .rst_n(rst_sync_n), .set_mask(set_m), .clr_mask(clr_m),
        .value(values[i*DATA_W +: DATA_W]), .irq(mbox_irq[i])
      );
    end
  endgenerate

  mbox_read_port #(.DATA_W(DATA_W), .NUM_BOXES(NUM_BOXES)) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .rd_en(rd_en), .hit(r_clr),
    .values(values), .rd_data(rd_data)
  );

  // R1: all interrupt lines low while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (mbox_irq == '0));
  // R7: no write in either port leaves every interrupt line unchanged
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wa_en && !wb_en) |=> $stable(mbox_irq));
endmodule

// File: tb/test_mbox_bank.sv
module test_mbox_bank;
  logic        clk;
  logic        rst_n;
  logic        wa_en, wb_en, rd_en;
  logic [7:0]  wa_addr, wb_addr, rd_addr;
  logic [31:0] wa_data, wb_data;
  logic [31:0] rd_data;
  logic [15:0] mbox_irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model [16];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          done = 0;

  mbox_bank i_mbox_bank (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .mbox_irq(mbox_irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int box_of(input logic [7:0] a, input int base);
    int off = int'(a) - base;
    if (a[1:0] != 2'b00 || off < 0 || off >= 64) return -1;
    return off / 4;
  endfunction

  function automatic logic [7:0] sa(input int c, input int m);
    return 8'(8'h80 + 16*c + 4*m);
  endfunction
  function automatic logic [7:0] ca(input int c, input int m);
    return 8'(8'hC0 + 16*c + 4*m);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one driven cycle; expected read data is pushed before the model is updated (R9)
  task automatic step(input logic ae, input logic [7:0] aa, input logic [31:0] ad,
                      input logic be, input logic [7:0] ba, input logic [31:0] bd,
                      input logic re, input logic [7:0] ra, input string tag);
    logic [31:0] s [16];
    logic [31:0] c [16];
    int k;
    @(negedge clk);
    wa_en = ae; wa_addr = aa; wa_data = ad;
    wb_en = be; wb_addr = ba; wb_data = bd;
    rd_en = re; rd_addr = ra;
    if (re) begin
      k = box_of(ra, 'hC0);
      exp_q.push_back(k >= 0 ? model[k] : 32'h0);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 16; i++) begin s[i] = '0; c[i] = '0; end
    if (ae) begin
      k = box_of(aa, 'h80); if (k >= 0) s[k] = s[k] | ad;
      k = box_of(aa, 'hC0); if (k >= 0) c[k] = c[k] | ad;
    end
    if (be) begin
      k = box_of(ba, 'h80); if (k >= 0) s[k] = s[k] | bd;
      k = box_of(ba, 'hC0); if (k >= 0) c[k] = c[k] | bd;
    end
    for (int i = 0; i < 16; i++) model[i] = (model[i] & ~c[i]) | s[i];
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, a, d, 0, 8'h0, 32'h0, 0, 8'h0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(0, 8'h0, 32'h0, 0, 8'h0, 32'h0, 1, a, tag);
  endtask

  task automatic check_irq(input string tag);
    logic [15:0] e;
    step(0, 8'h0, 32'h0, 0, 8'h0, 32'h0, 0, 8'h0, tag);
    for (int i = 0; i < 16; i++) e[i] = (model[i] != 0);
    check(tag, {16'h0, mbox_irq}, {16'h0, e});
  endtask

  // monitor: pops the expected read word one cycle after the read is sampled
  initial begin
    logic seen;
    forever begin
      @(posedge clk);
      seen = rd_en;
      @(negedge clk);
      if (seen && rst_n) begin
        if (exp_q.size() == 0) check("R4 unexpected read", rd_data, 32'hx);
        else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    rst_n = 0;
    wa_en = 0; wb_en = 0; rd_en = 0;
    wa_addr = 0; wb_addr = 0; rd_addr = 0; wa_data = 0; wb_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", {16'h0, mbox_irq}, 32'h0);
    for (int i = 0; i < 16; i++) rd(ca(i/4, i%4), "R1 mailbox zero after reset");

    // R2 set window ORs in data; R5 irq follows
    wr(sa(0, 0), 32'h0000_0005, "R2 set c0m0");
    wr(sa(2, 3), 32'h8000_0000, "R2 set c2m3");
    wr(sa(3, 1), 32'h00F0_0000, "R2 set c3m1");
    check_irq("R5 irq after sets");
    wr(sa(0, 0), 32'h0000_0100, "R2 OR into c0m0");
    rd(ca(0, 0), "R2 c0m0 holds OR");
    rd(ca(2, 3), "R2 c2m3 value");
    rd(ca(3, 1), "R4 c3m1 read via clear window");

    // R4 reads of set window and other addresses give zero
    rd(sa(0, 0), "R4 set window reads zero");
    rd(8'h10, "R4 outside window reads zero");

    // R3 clear lowest bit only, then the rest; R5 irq drops
    wr(ca(0, 0), 32'h0000_0001, "R3 clear bit0 c0m0");
    rd(ca(0, 0), "R3 c0m0 after clearing bit0");
    wr(ca(0, 0), 32'hFFFF_FFFF, "R3 clear all c0m0");
    check_irq("R5 irq low after clear");
    rd(ca(0, 0), "R3 c0m0 empty");

    // R6 same-cycle set and clear, set wins on overlap
    wr(sa(1, 2), 32'h0000_00FF, "R6 preload c1m2");
    step(1, sa(1, 2), 32'h0000_0F0F, 1, ca(1, 2), 32'h0000_0FF0, 0, 8'h0, "R6 set+clear");
    rd(ca(1, 2), "R6 set priority result");
    check_irq("R5 irq after R6");

    // R8 both ports set same mailbox
    step(1, sa(3, 3), 32'h1234_0000, 1, sa(3, 3), 32'h0000_5678, 0, 8'h0, "R8 dual set");
    rd(ca(3, 3), "R8 OR of both ports");

    // R7 out-of-window and unaligned writes ignored
    wr(8'h81, 32'hFFFF_FFFF, "R7 unaligned set");
    wr(8'hC2, 32'hFFFF_FFFF, "R7 unaligned clear");
    wr(8'h7C, 32'hFFFF_FFFF, "R7 below window");
    wr(8'h00, 32'hFFFF_FFFF, "R7 far address");
    check_irq("R7 irq unchanged");
    for (int i = 0; i < 16; i++) rd(ca(i/4, i%4), "R7 mailboxes unchanged");

    // R9 read in same cycle as write returns old value
    step(1, sa(0, 2), 32'hA5A5_0000, 0, 8'h0, 32'h0, 1, ca(0, 2), "R9 read before write");
    rd(ca(0, 2), "R9 value after write");
    step(1, ca(1, 2), 32'hFFFF_FFFF, 0, 8'h0, 32'h0, 1, ca(1, 2), "R9 read before clear");
    check_irq("R5 irq final");

    repeat (4) @(negedge clk);
    check("R4 all reads returned", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule